// File: doc/BRIEF.md
# Jittered Pulse Repetition Gate

This block turns a stream of carrier samples into a pulsed radar waveform. A period counter, programmed with a repetition length (PRT, in sample clocks) and an on-time (PW, in sample clocks), opens a gate at the start of every period and closes it after PW cycles. While the gate is open the carrier sample passes to the output unchanged. While it is closed the output sits at the mid-scale code, which is the zero level of an offset-binary converter.

In jitter mode each period length is moved away from PRT by a pseudo-random amount. The amount is taken from a 5-bit maximal-length shift register that steps once per period. It is centred on zero and scaled to PRT/128 per step, so the interval stays within one eighth of nominal on either side. New PRT, PW and mode values are taken only when a period begins, so a pulse is never cut short or stretched by a mid-period write. A one-cycle strobe marks the first cycle of every period, for downstream logic that is keyed to the pulse.

Top module: `pulse_jitter_mod`

## Requirements
- R1: While reset is asserted, and while `en` is low, `gate` and `sop` are 0 and `samp_out` equals the mid-scale code 1024 (bit 10 set, all other bits clear).
- R2: When `en` is sampled high at a clock edge while the block is idle, a period begins at that edge: `sop` is 1 in the cycle that follows.
- R3: With jitter off, every period lasts exactly PRT cycles, so consecutive `sop` pulses are PRT cycles apart.
- R4: `gate` is 1 during the first PW cycles of each period and 0 for the rest of it. PW = 0 gives no gate, and PW at or above the period length keeps the gate open for the whole period.
- R5: `samp_out` equals `samp_in` in the same cycle whenever `gate` is 1, and equals 1024 whenever `gate` is 0.
- R6: `sop` is 1 only in the first cycle of each period and lasts one cycle per period.
- R7: The values of `prt`, `pw` and `jit_en` are sampled only at the clock edge that begins a period. Changes at other times do not affect the period in progress.
- R8: With jitter on, a period that begins while the shift register holds value L lasts PRT + floor((L - 16) * PRT / 128) cycles.
- R9: The shift register is 5 bits wide and resets to 1. At every period start, in either mode, it moves to {q[3:0], q[4] ^ q[2]}. It never holds 0, so the period lengths in jitter mode repeat every 31 periods.
- R10: When `en` is sampled low, the block is idle from the next cycle on: the gate closes and no strobe appears. The shift register keeps its value.
- R11: With jitter on, the offset D from PRT satisfies -15*PRT - 127 <= 128*D <= 15*PRT, which is within 12.5% of PRT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Runs the period counter while high |
| jit_en | input | 1 | Selects jittered period lengths |
| prt | input | CNT_W | Nominal repetition length in clocks |
| pw | input | CNT_W | Pulse on-time in clocks |
| samp_in | input | SAMP_W | Carrier sample, offset binary |
| gate | output | 1 | Pulse gate |
| sop | output | 1 | Start-of-period strobe |
| samp_out | output | SAMP_W | Gated sample, mid-scale when closed |

## Verification
The assertions assume that PRT is at least 1 with jitter off and at least 2 with jitter on. Below those values a jittered period could come out with zero length, and the bound on the period counter would not hold. The stimulus keeps to these limits: the smallest PRT it drives in jitter mode is 2, and it changes PRT and PW only at the negative clock edge. Each input pattern is fed at the same time to a cycle model built from the requirements, and that model predicts the gate and strobe at every cycle, including the edges that begin, end or restart a run.

// File: rtl/pjm_pkg.sv
package pjm_pkg;
    localparam int LFSR_W = 5;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 5'd1;
    localparam int JIT_CENTER = 16;
    localparam int JIT_SHIFT = 7;
endpackage

// File: rtl/pjm_lfsr_next.sv
module pjm_lfsr_next
    import pjm_pkg::*;
(
    input  logic [LFSR_W-1:0] cur,
    output logic [LFSR_W-1:0] nxt
);
    // x^5 + x^3 + 1, Fibonacci form
    assign nxt = {cur[LFSR_W-2:0], cur[4] ^ cur[2]};
endmodule

// File: rtl/pjm_len_calc.sv
module pjm_len_calc
    import pjm_pkg::*;
#(
    parameter int CNT_W = 20,
    localparam int LEN_W = CNT_W + 1,
    localparam int PRD_W = CNT_W + LFSR_W + 2
)(
    input  logic [CNT_W-1:0]  prt,
    input  logic [LFSR_W-1:0] lfsr,
    input  logic              jit,
    output logic [LEN_W-1:0]  len
);
    logic signed [LFSR_W:0] centred;
    logic signed [PRD_W-1:0] prod;
    logic signed [PRD_W-1:0] offset;

    always_comb begin
        centred = $signed({1'b0, lfsr}) - (LFSR_W+1)'(JIT_CENTER);
        prod    = PRD_W'(centred) * $signed({{(PRD_W-CNT_W){1'b0}}, prt});
        offset  = prod >>> JIT_SHIFT;
        if (jit)
            len = LEN_W'($signed({{(PRD_W-CNT_W){1'b0}}, prt}) + offset);
        else
            len = {1'b0, prt};
    end
endmodule

// File: rtl/pjm_gate_out.sv
module pjm_gate_out #(
    parameter int CNT_W  = 20,
    parameter int SAMP_W = 11,
    localparam int LEN_W = CNT_W + 1,
    localparam logic [SAMP_W-1:0] MID = SAMP_W'(1) << (SAMP_W - 1)
)(
    input  logic              run,
    input  logic [LEN_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  pw,
    input  logic [SAMP_W-1:0] samp_in,
    output logic              gate,
    output logic              sop,
    output logic [SAMP_W-1:0] samp_out
);
    always_comb begin
        gate     = run && (cnt < {1'b0, pw});
        sop      = run && (cnt == '0);
        samp_out = gate ? samp_in : MID;
    end
endmodule

// File: rtl/pulse_jitter_mod.sv
module pulse_jitter_mod
    import pjm_pkg::*;
#(
    parameter int CNT_W  = 20,
    parameter int SAMP_W = 11,
    localparam int LEN_W = CNT_W + 1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              jit_en,
    input  logic [CNT_W-1:0]  prt,
    input  logic [CNT_W-1:0]  pw,
    input  logic [SAMP_W-1:0] samp_in,
    output logic              gate,
    output logic              sop,
    output logic [SAMP_W-1:0] samp_out
);
    typedef struct packed {
        logic              run;
        logic [LEN_W-1:0]  cnt;
        logic [LEN_W-1:0]  len;
        logic [CNT_W-1:0]  pw;
        logic [CNT_W-1:0]  prt;
        logic              jit;
        logic [LFSR_W-1:0] lfsr;
    } state_t;

    state_t s_d, s_q;
    logic [LFSR_W-1:0] lfsr_nxt;
    logic [LEN_W-1:0]  len_new;
    logic              last;

    pjm_lfsr_next u_lfsr (
        .cur (s_q.lfsr),
        .nxt (lfsr_nxt)
    );

    pjm_len_calc #(.CNT_W(CNT_W)) u_len (
        .prt  (prt),
        .lfsr (s_q.lfsr),
        .jit  (jit_en),
        .len  (len_new)
    );

    pjm_gate_out #(.CNT_W(CNT_W), .SAMP_W(SAMP_W)) u_out (
        .run      (s_q.run),
        .cnt      (s_q.cnt),
        .pw       (s_q.pw),
        .samp_in  (samp_in),
        .gate     (gate),
        .sop      (sop),
        .samp_out (samp_out)
    );

    always_comb begin
        s_d  = s_q;
        last = (s_q.cnt == s_q.len - LEN_W'(1));
        if (!en) begin
            s_d.run = 1'b0;
            s_d.cnt = '0;
        end else if (!s_q.run || last) begin
            s_d.run  = 1'b1;
            s_d.cnt  = '0;
            s_d.len  = len_new;
            s_d.pw   = pw;
            s_d.prt  = prt;
            s_d.jit  = jit_en;
            s_d.lfsr = lfsr_nxt;
        end else begin
            s_d.cnt = s_q.cnt + LEN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.lfsr <= LFSR_SEED;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/pulse_jitter_mod_chk.sv
module pulse_jitter_mod_chk #(
    parameter int CNT_W  = 20,
    parameter int SAMP_W = 11,
    localparam int LEN_W = CNT_W + 1
)(
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              gate,
    input logic              sop,
    input logic [SAMP_W-1:0] samp_out,
    input logic              run_q,
    input logic [LEN_W-1:0]  cnt_q,
    input logic [LEN_W-1:0]  len_q,
    input logic [CNT_W-1:0]  prt_q,
    input logic              jit_q,
    input logic [4:0]        lfsr_q
);
    localparam logic [SAMP_W-1:0] MID = SAMP_W'(1) << (SAMP_W - 1);
    longint diff, nom;

    always_comb begin
        diff = longint'(len_q) - longint'(prt_q);
        nom  = longint'(prt_q);
    end

    AST_IDLE_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!gate && !sop)); // R10
    AST_MIDSCALE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |-> samp_out == MID); // R5
    AST_START_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !run_q) |=> sop); // R2
    AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> cnt_q < len_q); // R3
    AST_FIXED_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !jit_q) |-> diff == 0); // R3
    AST_JITTER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && jit_q) |-> ((diff * 128 <= 15 * nom) && (diff * 128 >= -15 * nom - 127))); // R11
    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != 5'd0); // R9
    AST_LFSR_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(lfsr_q)); // R10
endmodule

bind pulse_jitter_mod pulse_jitter_mod_chk #(.CNT_W(CNT_W), .SAMP_W(SAMP_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .gate     (gate),
    .sop      (sop),
    .samp_out (samp_out),
    .run_q    (s_q.run),
    .cnt_q    (s_q.cnt),
    .len_q    (s_q.len),
    .prt_q    (s_q.prt),
    .jit_q    (s_q.jit),
    .lfsr_q   (s_q.lfsr)
);

// File: tb/pulse_jitter_mod_tb.sv
module pulse_jitter_mod_tb;
    localparam int CNT_W  = 20;
    localparam int SAMP_W = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic jit_en = 1'b0;
    logic [CNT_W-1:0] prt = '0;
    logic [CNT_W-1:0] pw = '0;
    logic [SAMP_W-1:0] samp_in = '0;
    logic gate, sop;
    logic [SAMP_W-1:0] samp_out;

    pulse_jitter_mod #(.CNT_W(CNT_W), .SAMP_W(SAMP_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .jit_en(jit_en),
        .prt(prt), .pw(pw), .samp_in(samp_in),
        .gate(gate), .sop(sop), .samp_out(samp_out)
    );

    always #10 clk = ~clk;

    typedef struct {
        bit    g;
        bit    s;
        string tag;
    } exp_t;

    exp_t  sb[$];
    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    // reference state
    bit     m_run = 1'b0;
    longint m_cnt = 0, m_len = 0, m_pw = 0;
    int     m_lfsr = 1;

    // sop recorder
    bit     rec = 1'b0;
    longint cyc = 0;
    longint sop_t[$];

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver: predicts the state after the coming rising edge, then waits
    task automatic step();
        exp_t e;
        longint l;
        if (!rst_n) begin
            m_run = 1'b0; m_cnt = 0; m_len = 0; m_pw = 0; m_lfsr = 1;
        end else if (!en) begin
            m_run = 1'b0; m_cnt = 0;
        end else if (!m_run || m_cnt == m_len - 1) begin
            l = longint'(m_lfsr);
            m_run = 1'b1;
            m_cnt = 0;
            m_pw  = longint'(pw);
            if (jit_en)
                m_len = longint'(prt) + (((l - 16) * longint'(prt)) >>> 7);
            else
                m_len = longint'(prt);
            m_lfsr = ((m_lfsr << 1) & 31) | (((m_lfsr >> 4) ^ (m_lfsr >> 2)) & 1);
        end else begin
            m_cnt++;
        end
        e.g = m_run && (m_cnt < m_pw);
        e.s = m_run && (m_cnt == 0);
        e.tag = cur_tag;
        sb.push_back(e);
        @(negedge clk);
        samp_in = samp_in + 11'd37;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // monitor
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            cyc++;
            if (rec && sop) sop_t.push_back(cyc);
            if (sb.size() > 0) begin
                e = sb.pop_front();
                check(gate == e.g, {e.tag, "/R4 gate"}, longint'(gate), longint'(e.g));
                check(sop == e.s, {e.tag, "/R6 sop"}, longint'(sop), longint'(e.s));
                check(samp_out == (e.g ? samp_in : 11'd1024), {e.tag, "/R5 samp_out"},
                      longint'(samp_out), longint'(e.g ? samp_in : 11'd1024));
            end
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        longint lo, hi, g, p;
        bit rep_ok;
        // R1: reset state
        cur_tag = "R1";
        cycles(4);
        rst_n = 1'b1;
        cycles(3);

        // R2, R3: fixed period, PRT 10, PW 3
        cur_tag = "R2_R3";
        prt = 10; pw = 3; en = 1'b1;
        rec = 1'b1;
        cycles(40);
        rec = 1'b0;
        cycles(1);
        for (int i = 1; i < sop_t.size(); i++)
            check(sop_t[i] - sop_t[i-1] == 10, "R3 fixed period", sop_t[i] - sop_t[i-1], 10);
        check(sop_t.size() >= 4, "R3 strobe count", sop_t.size(), 4);
        sop_t.delete();

        // R7: mid-period change takes effect at the next start only
        cur_tag = "R7";
        cycles(3);
        prt = 7; pw = 5;
        cycles(30);

        // R4: PW of zero, and PW longer than the period
        cur_tag = "R4_pw0";
        pw = 0;
        cycles(20);
        cur_tag = "R4_pwlong";
        prt = 6; pw = 20;
        cycles(20);

        // R10: disable mid-period, then restart (R2)
        cur_tag = "R10";
        prt = 9; pw = 4;
        cycles(12);
        en = 1'b0;
        cycles(6);
        cur_tag = "R2_restart";
        en = 1'b1;
        cycles(15);
        en = 1'b0;
        cycles(3);

        // R8, R9, R11: jitter on PRT 256
        cur_tag = "R8_R9";
        prt = 256; pw = 40; jit_en = 1'b1; en = 1'b1;
        rec = 1'b1;
        cycles(256 * 70);
        rec = 1'b0;
        cycles(1);
        lo = 1 << 30; hi = 0;
        for (int i = 1; i < sop_t.size(); i++) begin
            g = sop_t[i] - sop_t[i-1];
            if (g < lo) lo = g;
            if (g > hi) hi = g;
            check(((g - 256) * 128 <= 15 * 256) && ((g - 256) * 128 >= -15 * 256 - 127),
                  "R11 jitter bound", g, 256);
        end
        check(lo < 256, "R8 shorter period seen", lo, 255);
        check(hi > 256, "R8 longer period seen", hi, 257);
        rep_ok = 1'b1;
        for (int i = 1; i + 31 < sop_t.size(); i++) begin
            g = sop_t[i] - sop_t[i-1];
            p = sop_t[i+31] - sop_t[i+30];
            if (g != p) rep_ok = 1'b0;
        end
        check(rep_ok && sop_t.size() > 40, "R9 31-period repeat", longint'(rep_ok), 1);
        sop_t.delete();

        // R8: smallest allowed PRT in jitter mode
        cur_tag = "R8_small";
        prt = 2; pw = 1;
        cycles(80);
        en = 1'b0;
        jit_en = 1'b0;
        cur_tag = "R1_idle";
        cycles(5);

        while (sb.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule